// File: doc/BRIEF.md
# Tri-state phase-frequency detector with lock flag

This block compares two edge streams sampled on one system clock: a divided reference (the R stream) and a divided oscillator (the V stream). It finds rising transitions on both raw inputs and keeps one pending flag per stream. The flag for a stream is set by that stream's rising edge. When both flags are set, a hold counter keeps them set for a fixed minimum width and then clears both together. The loop error is reported in two ways. The first is a single-ended output with three levels: sinking, sourcing or floating. It is given as a drive value plus an output enable. The second is a pair of active-low direction pulses.

When the V edge comes first, or the V stream runs faster, the V pulse output goes low and the single-ended output sinks. When the R edge comes first, the R pulse output goes low and the single-ended output sources. When the two edges land in the same cycle, both pulse outputs go low together for only the minimum width and the single-ended output never leaves high impedance. A lock flag is high except during clocks in which exactly one flag is pending. It therefore pulses low in step with every phase or frequency error.

The inputs are plain control levels, not a data stream, so no valid/ready handshake applies. An outer loop combines the outputs into a charge-pump control or a lock monitor.

Top module: `tristate_pfd`

## Requirements
- R1: While reset is asserted (rst_n low), phi_r_n and phi_v_n are high, pd_oe is low and lock is high.
- R2: Only a low-to-high transition of ref_in or vco_in counts as an edge. A level held high yields one edge. A rising transition first seen at a clock edge shows on the outputs two clock edges later.
- R3: When the V edge precedes the R edge by d clocks, phi_v_n is low for d+MIN_W consecutive clocks and phi_r_n is low only for the last MIN_W of those clocks. A further V edge while V is already pending has no effect.
- R4: When the R edge precedes the V edge by d clocks, phi_r_n is low for d+MIN_W clocks and phi_v_n is low only for the last MIN_W of them.
- R5: Edges on both inputs in the same clock make phi_r_n and phi_v_n low together for exactly MIN_W clocks (default 2), and both return high in the same clock.
- R6: While only the V flag is pending, pd_oe is 1 and pd_drv is 0 (a sinking pulse).
- R7: While only the R flag is pending, pd_oe is 1 and pd_drv is 1 (a sourcing pulse).
- R8: While neither flag or both flags are pending, pd_oe is 0 (high impedance).
- R9: lock is low in exactly those clocks in which exactly one of phi_r_n and phi_v_n is low, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference level, synchronous to clk |
| vco_in | input | 1 | Divided oscillator level, synchronous to clk |
| pd_drv | output | 1 | Single-ended drive value, 1 = source, 0 = sink; meaningful only when pd_oe is 1 |
| pd_oe | output | 1 | Single-ended output enable; 0 = high impedance |
| phi_r_n | output | 1 | Active-low pulse: R stream ahead / V too slow |
| phi_v_n | output | 1 | Active-low pulse: V stream ahead / V too fast |
| lock | output | 1 | High when in lock; low while exactly one stream is pending |

## Verification
The assertions assume that both raw inputs are already synchronous to clk. They also assume that no new rising edge arrives while both flags are pending and the hold counter is running. Under that assumption the two pulse outputs always return high in the same clock, and a coincident overlap always lasts at least two clocks. The stimulus gives at most one event pair per scenario window. Each pulse is one clock wide, except where a level is held high on purpose. Every lagging edge arrives before the minimum-width hold begins, and the window is long enough for the flags to clear before the next scenario starts.

// File: rtl/tpfd_pkg.sv
package tpfd_pkg;

  typedef struct packed {
    logic r;
    logic v;
  } tpfd_pend_t;

  typedef enum logic [1:0] {
    SE_FLOAT  = 2'd0,
    SE_SINK   = 2'd1,
    SE_SOURCE = 2'd2
  } tpfd_se_e;

endpackage

// File: rtl/tpfd_rise.sv
module tpfd_rise #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw,
  output logic [NCH-1:0] rise
);

  logic [NCH-1:0] prev;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[g] <= 1'b0;
        rise[g] <= 1'b0;
      end else begin
        prev[g] <= raw[g];
        rise[g] <= raw[g] & ~prev[g];
      end
    end
  end

endmodule

// File: rtl/tpfd_core.sv
module tpfd_core
  import tpfd_pkg::*;
#(
  parameter int MIN_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_r,
  input  logic       rise_v,
  output tpfd_pend_t pend
);

  localparam int CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

  logic [CW-1:0] hold_cnt;
  logic          both;
  logic          release_now;

  assign both        = pend.r & pend.v;
  assign release_now = both && (hold_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      hold_cnt <= '0;
    end else if (release_now) begin
      pend     <= '0;
      hold_cnt <= '0;
    end else begin
      pend.r <= pend.r | rise_r;
      pend.v <= pend.v | rise_v;
      if (both) hold_cnt <= hold_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tpfd_outmap.sv
module tpfd_outmap
  import tpfd_pkg::*;
(
  input  tpfd_pend_t pend,
  output logic       pd_drv,
  output logic       pd_oe,
  output logic       phi_r_n,
  output logic       phi_v_n,
  output logic       lock
);

  tpfd_se_e se_mode;

  always_comb begin
    unique case ({pend.r, pend.v})
      2'b01:   se_mode = SE_SINK;
      2'b10:   se_mode = SE_SOURCE;
      default: se_mode = SE_FLOAT;
    endcase
  end

  always_comb begin
    pd_oe  = (se_mode != SE_FLOAT);
    pd_drv = (se_mode == SE_SOURCE);
  end

  assign phi_r_n = ~pend.r;
  assign phi_v_n = ~pend.v;
  assign lock    = (se_mode == SE_FLOAT);

endmodule

// File: rtl/tristate_pfd.sv
module tristate_pfd
  import tpfd_pkg::*;
#(
  parameter int MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic vco_in,
  output logic pd_drv,
  output logic pd_oe,
  output logic phi_r_n,
  output logic phi_v_n,
  output logic lock
);

  logic [1:0] rise;
  tpfd_pend_t pend;

  tpfd_rise #(.NCH(2)) u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({ref_in, vco_in}),
    .rise (rise)
  );

  tpfd_core #(.MIN_W(MIN_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .rise_r(rise[1]),
    .rise_v(rise[0]),
    .pend  (pend)
  );

  tpfd_outmap u_out (
    .pend   (pend),
    .pd_drv (pd_drv),
    .pd_oe  (pd_oe),
    .phi_r_n(phi_r_n),
    .phi_v_n(phi_v_n),
    .lock   (lock)
  );

endmodule

// File: rtl/tristate_pfd_chk.sv
module tristate_pfd_chk #(
  parameter int MIN_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ref_in,
  input logic vco_in,
  input logic pd_drv,
  input logic pd_oe,
  input logic phi_r_n,
  input logic phi_v_n,
  input logic lock
);

  // R6: a lone V pulse makes the single-ended output sink
  p_sink_on_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi_v_n && phi_r_n) |-> (pd_oe && !pd_drv));

  // R7: a lone R pulse makes the single-ended output source
  p_source_on_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi_r_n && phi_v_n) |-> (pd_oe && pd_drv));

  // R8: float when both pulses are active or neither is
  p_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_r_n == phi_v_n) |-> !pd_oe);

  // R9: lock tracks a one-sided error
  p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock == (phi_r_n == phi_v_n));

  // R5: both pulses end in the same clock
  p_joint_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi_v_n) |-> $rose(phi_r_n));

  // R5: the pulses never both start while idle without both staying low at least one more clock
  if (MIN_W >= 2) begin : g_minw
    p_min_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi_r_n && !phi_v_n && $past(phi_r_n || phi_v_n)) |=> (!phi_r_n && !phi_v_n));
  end

  // R2: an output pulse starts only after a raw rising transition two clocks earlier
  p_edge_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi_v_n) |-> $past(vco_in, 2) && !$past(vco_in, 3));

endmodule

bind tristate_pfd tristate_pfd_chk #(.MIN_W(MIN_W)) u_chk (.*);

// File: tb/tristate_pfd_test.sv
`timescale 1ns/1ps
module tristate_pfd_test;

  localparam int MIN_W = 2;
  localparam int WIN   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic vco_in = 1'b0;
  logic pd_drv, pd_oe, phi_r_n, phi_v_n, lock;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tristate_pfd #(.MIN_W(MIN_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
    .pd_drv(pd_drv), .pd_oe(pd_oe), .phi_r_n(phi_r_n), .phi_v_n(phi_v_n),
    .lock(lock)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "phi_r_n in reset", int'(phi_r_n), 1);
    check("R1", "phi_v_n in reset", int'(phi_v_n), 1);
    check("R1", "pd_oe in reset", int'(pd_oe), 0);
    check("R1", "lock in reset", int'(lock), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // tv/tv2/tr: cycle indices at which a raw rising edge is applied (-1 = none)
  task automatic t_case(string req, int tv, int tv2, int tr, bit hold);
    int v_low = 0, r_low = 0, both_low = 0, sink = 0, source = 0;
    int lock_low = 0, bad_float = 0, first_v = -1, first_r = -1;
    int fv, fr, last, lead;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      if (!phi_v_n) begin v_low++; if (first_v < 0) first_v = c; end
      if (!phi_r_n) begin r_low++; if (first_r < 0) first_r = c; end
      if (!phi_v_n && !phi_r_n) both_low++;
      if (pd_oe && !pd_drv) sink++;
      if (pd_oe && pd_drv) source++;
      if (!lock) lock_low++;
      if ((phi_v_n == phi_r_n) && pd_oe) bad_float++;
      if (hold) begin
        vco_in = (c >= tv && c < WIN - 5);
        ref_in = (c >= tr && c < WIN - 5);
      end else begin
        vco_in = (c == tv) || (c == tv2);
        ref_in = (c == tr);
      end
    end
    vco_in = 1'b0;
    ref_in = 1'b0;
    fv   = tv + 2;
    fr   = tr + 2;
    last = ((fv > fr) ? fv : fr) + MIN_W;
    lead = (fv > fr) ? fv - fr : fr - fv;
    check("R2", {req, " first V low cycle"}, first_v, fv);
    check("R2", {req, " first R low cycle"}, first_r, fr);
    check(req, "phi_v_n low clocks", v_low, last - fv);
    check(req, "phi_r_n low clocks", r_low, last - fr);
    check("R5", {req, " overlap clocks"}, both_low, MIN_W);
    check("R6", {req, " sink clocks"}, sink, (fr > fv) ? lead : 0);
    check("R7", {req, " source clocks"}, source, (fv > fr) ? lead : 0);
    check("R8", {req, " enable while balanced"}, bad_float, 0);
    check("R9", {req, " lock low clocks"}, lock_low, lead);
  endtask

  initial begin
    t_reset();
    t_case("R3", 2, -1, 7, 1'b0);   // V leads by 5
    t_case("R4", 7, -1, 3, 1'b0);   // R leads by 4
    t_case("R3", 1, 4, 10, 1'b0);   // V faster: second V edge while pending
    t_case("R5", 2, -1, 2, 1'b1);   // coincident, levels held high (R2)
    t_case("R4", 3, -1, 2, 1'b0);   // V lags by one clock
    t_case("R3", 2, -1, 3, 1'b0);   // V leads by one clock
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule